// File: doc/BRIEF.md
# Logarithmic-Depth Parallel-Prefix Binary Adder

This block adds two unsigned N-bit operands and a carry-in. It returns an N-bit sum and a carry-out. It is purely combinational. Each bit position first forms a generate term (both operand bits set) and a propagate term (operand bits differ).

A two-sweep prefix tree then merges these pairs into group terms that span every low-order span [0..i]. The up-sweep combines pairs at strides of 2, 4, 8 and so on, which completes the prefixes that end at positions 1, 3, 7, 15. The down-sweep fills the remaining positions in the reverse order of strides. The tree depth is therefore about 2·log2(N) operator levels, not N.

The carry-in enters only after the tree, as a generate term one position below bit 0. Every sum bit is then a single XOR of its propagate term and its carry. The block drops into any datapath that needs a wide, fast add, for example an address or accumulate path.

Top module: `bk_prefix_adder`

## Requirements
- R1: For every input combination, the concatenation {cout, sum} equals the arithmetic value a + b + cin taken to N+1 bits.
- R2: cout is 1 exactly when a + b + cin is at least 2^N; otherwise cout is 0.
- R3: When every bit position propagates (a XOR b all ones, a AND b all zeros), the carry-in passes through the whole width. With cin=0 the result is sum all ones and cout=0. With cin=1 the result is sum all zeros and cout=1.
- R4: Each internal carry satisfies the ripple recurrence carry[i+1] = g[i] OR (p[i] AND carry[i]), where carry[0] = cin. A single generate at bit j, followed by propagating bits above it, therefore clears every sum bit from j upward and sets cout.
- R5: With b all zeros and cin=0, sum equals a and cout is 0. All-zero inputs give an all-zero sum and cout=0.
- R6: With both operands zero and cin=1, the result is sum = 1 and cout = 0.
- R7: The results are valid in the same cycle as the operands, with no register in the path. N must be a power of two, and its default is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
Every result of this adder is due in the same cycle as its operands, because no register lies between the inputs and sum or cout. The bench applies a vector just after a rising edge and pushes the expected N+1-bit value, computed with plain integer addition, into a queue. It pops and compares that value at the following falling edge, half a period later, once the combinational tree has settled. The bound checker evaluates its immediate assertions whenever the operands or the internal carry vector change. It skips any evaluation while the inputs are still unknown.

// File: rtl/bk_adder_pkg.sv
package bk_adder_pkg;

  // Field order matters: a {g, p} concatenation maps onto this struct.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge a more significant span (hi) with the span just below it (lo).
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Carry out of a span [0..i], given the carry entering bit 0.
  function automatic logic carry_fold(gp_t grp, logic cin);
    return grp.g | (grp.p & cin);
  endfunction

endpackage

// File: rtl/bk_pg_gen.sv
module bk_pg_gen #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] g,
  output logic [N-1:0] p
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree
  import bk_adder_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  output logic [N-1:0] grp_g,
  output logic [N-1:0] grp_p
);
  localparam int L = $clog2(N);

  // Up-sweep levels: index k holds the terms after k merge stages.
  logic [N-1:0] ug [0:L];
  logic [N-1:0] up [0:L];
  assign ug[0] = g;
  assign up[0] = p;

  for (genvar k = 0; k < L; k++) begin : g_up
    localparam int S = 2 ** (k + 1);
    localparam int H = S / 2;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i + 1) % S) == 0) begin : g_node
        gp_t r;
        assign r = gp_merge({ug[k][i], up[k][i]}, {ug[k][i-H], up[k][i-H]});
        assign ug[k+1][i] = r.g;
        assign up[k+1][i] = r.p;
      end else begin : g_pass
        assign ug[k+1][i] = ug[k][i];
        assign up[k+1][i] = up[k][i];
      end
    end
  end

  // Down-sweep levels: fill positions that sit halfway between complete ones.
  logic [N-1:0] dg [0:L-1];
  logic [N-1:0] dp [0:L-1];
  assign dg[0] = ug[L];
  assign dp[0] = up[L];

  for (genvar j = 1; j < L; j++) begin : g_dn
    localparam int K = L - 1 - j;
    localparam int S = 2 ** (K + 1);
    localparam int H = S / 2;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if ((((i + 1) % S) == H) && (i >= S)) begin : g_node
        gp_t r;
        assign r = gp_merge({dg[j-1][i], dp[j-1][i]}, {dg[j-1][i-H], dp[j-1][i-H]});
        assign dg[j][i] = r.g;
        assign dp[j][i] = r.p;
      end else begin : g_pass
        assign dg[j][i] = dg[j-1][i];
        assign dp[j][i] = dp[j-1][i];
      end
    end
  end

  assign grp_g = dg[L-1];
  assign grp_p = dp[L-1];
endmodule

// File: rtl/bk_sum_gen.sv
module bk_sum_gen
  import bk_adder_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] grp_g,
  input  logic [N-1:0] grp_p,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic [N-1:0] sum
);
  assign carry[0] = cin;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign carry[i+1] = carry_fold({grp_g[i], grp_p[i]}, cin);
    assign sum[i]     = p[i] ^ carry[i];
  end
endmodule

// File: rtl/bk_prefix_adder.sv
module bk_prefix_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  // Named internal wires, also watched by the bound checker.
  logic [N-1:0] bit_g;
  logic [N-1:0] bit_p;
  logic [N-1:0] span_g;
  logic [N-1:0] span_p;
  logic [N:0]   carry_vec;

  bk_pg_gen #(.N(N)) pg_i (
    .a(a), .b(b), .g(bit_g), .p(bit_p)
  );

  bk_prefix_tree #(.N(N)) tree_i (
    .g(bit_g), .p(bit_p), .grp_g(span_g), .grp_p(span_p)
  );

  bk_sum_gen #(.N(N)) sum_i (
    .p(bit_p), .grp_g(span_g), .grp_p(span_p), .cin(cin),
    .carry(carry_vec), .sum(sum)
  );

  assign cout = carry_vec[N];
endmodule

// File: rtl/bk_prefix_adder_chk.sv
module bk_prefix_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] bit_g,
  input logic [N-1:0] bit_p,
  input logic [N:0]   carry_vec
);
  logic [N:0] arith;
  assign arith = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_arith_total_R1: assert ({cout, sum} == arith)
        else $error("R1 total mismatch");
      assert_cout_range_R2: assert (cout == (arith >= (N+1)'(2) ** N))
        else $error("R2 carry-out mismatch");
      assert_full_run_R3: assert (!((a ^ b) == '1) || (cout == cin && sum == {N{~cin}}))
        else $error("R3 full propagate mismatch");
      assert_ripple_base_R4: assert (carry_vec[0] == cin)
        else $error("R4 carry[0] mismatch");
      for (int i = 0; i < N; i++) begin
        assert_ripple_step_R4: assert (carry_vec[i+1] == (bit_g[i] | (bit_p[i] & carry_vec[i])))
          else $error("R4 carry recurrence broken");
      end
      assert_identity_R5: assert (!(b == '0 && !cin) || (sum == a && !cout))
        else $error("R5 identity mismatch");
    end
  end
endmodule

bind bk_prefix_adder bk_prefix_adder_chk #(.N(N)) chk_i (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .bit_g(bit_g), .bit_p(bit_p), .carry_vec(carry_vec)
);

// File: tb/bk_prefix_adder_tb_top.sv
module bk_prefix_adder_tb_top;
  localparam int N       = 16;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic [N-1:0] a   = '0;
  logic [N-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sum;
  logic         cout;

  int applied = 0;
  int bad     = 0;
  bit done    = 1'b0;

  logic [N:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PER / 2) clk = ~clk;

  bk_prefix_adder #(.N(N)) dut_i (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  // Drive after a rising edge, queue the reference, compare at the falling edge.
  task automatic apply(input logic [N-1:0] va, input logic [N-1:0] vb,
                       input logic vc, input string tag);
    logic [N:0] want;
    logic [N:0] got;
    @(posedge clk);
    a   = va;
    b   = vb;
    cin = vc;
    want = (N+1)'(va) + (N+1)'(vb) + (N+1)'(vc);
    exp_q.push_back(want);
    tag_q.push_back(tag);
    @(negedge clk);
    want = exp_q.pop_front();
    got  = {cout, sum};
    applied++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: a=%h b=%h cin=%0d got=%h expected=%h",
               tag_q.pop_front(), va, vb, vc, got, want);
    end else begin
      void'(tag_q.pop_front());
    end
  endtask

  initial begin
    // R5: zero state and identity
    apply('0, '0, 1'b0, "R5 zero");
    apply(16'h1234, '0, 1'b0, "R5 identity");
    apply(16'hFFFF, '0, 1'b0, "R5 identity max");
    // R6: carry-in alone
    apply('0, '0, 1'b1, "R6 cin only");
    // R3: full propagate, both carry-in values and several splits
    apply(16'h5555, 16'hAAAA, 1'b0, "R3 run cin0");
    apply(16'h5555, 16'hAAAA, 1'b1, "R3 run cin1");
    apply(16'hFFFF, 16'h0000, 1'b1, "R3 run ones");
    apply(16'h00FF, 16'hFF00, 1'b1, "R3 run split");
    // R2: carry-out boundary
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R2 max");
    apply(16'h8000, 16'h8000, 1'b0, "R2 top gen");
    apply(16'h7FFF, 16'h8000, 1'b0, "R2 just below");
    // R4: single generate at bit j, propagate above
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] above;
      above = ~((N'(1) << (j + 1)) - N'(1));
      apply((N'(1) << j) | above, N'(1) << j, 1'b0, "R4 gen walk");
    end
    // R1: propagate runs of every length and start, entered by a generate or the carry-in
    for (int s = 0; s < N; s++) begin
      for (int len = 1; len + s <= N; len++) begin
        logic [N-1:0] mask;
        logic [N-1:0] r;
        logic [N-1:0] va;
        logic [N-1:0] vb;
        mask = ((N'(1) << len) - N'(1)) << s;
        if (len == N) mask = '1;
        r  = N'($urandom);
        va = r & mask;
        vb = ~r & mask;
        if (s > 0) begin
          va[s-1] = 1'b1;
          vb[s-1] = 1'b1;
        end
        apply(va, vb, (s == 0), "R1 run");
      end
    end
    // R1/R7: random operands, results checked in the same cycle
    for (int n = 0; n < 1500; n++) begin
      apply(N'($urandom), N'($urandom), 1'($urandom), "R1 R7 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule